// File: doc/BRIEF.md
# Source-Route Tag Byte Forwarder

This block is the forwarding decision stage of a core switch inside a fabric with two aggregation layers. A packet crossing the fabric carries its whole route as a 32-bit tag. The tag holds four one-byte hop fields: two hops for the climb towards the top of the fabric and two hops for the descent. Each core switch reads only the one byte that belongs to its own position. The output port comes from that byte alone, with no address lookup.

Upstream logic presents an already extracted tag with a one-cycle valid strobe. Two static configuration bits come with it. One gives the switch's tier (first or second aggregation layer). The other gives the direction of travel (up or down). The block picks the matching hop byte and truncates it to the port-number width. It also flags the packet for drop when the byte names a port that does not exist. The result is registered, so one decision is produced every cycle for back-to-back tags.

Top module: `srtag_fwd`

## Requirements
- R1: The hop byte is chosen by the index {dirDown, tierSel}. Index 0 (up, first tier) uses tag bits 31:24. Index 1 (up, second tier) uses bits 23:16. Index 2 (down, first tier) uses bits 15:8. Index 3 (down, second tier) uses bits 7:0.
- R2: outPort equals the low PORT_W bits of the selected hop byte (default PORT_W = 4).
- R3: outDrop is 1 exactly when the full 8-bit selected byte is greater than or equal to PORT_COUNT (default 12). Otherwise it is 0, and this holds even when the truncated port bits look in range.
- R4: outValid is 1 in the cycle after a cycle with tagValid = 1, and 0 in the cycle after a cycle with tagValid = 0.
- R5: Tags presented on consecutive cycles each produce their own result on consecutive cycles, with no gap or stall.
- R6: When tagValid is 0, outPort and outDrop keep the values of the last accepted tag.
- R7: A synchronous reset (rst = 1 at a rising edge) clears outValid, outPort and outDrop to 0. Reset takes priority over a tagValid presented in the same cycle.
- R8: tierSel and dirDown are sampled in the same cycle as tagValid, so a configuration change takes effect on the very next accepted tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tagValid | input | 1 | Strobe: tagWord holds a parsed route tag this cycle |
| tagWord | input | 32 | Four hop bytes, up-hop 1 in the top byte, down-hop 2 in the bottom byte |
| tierSel | input | 1 | 0 = first aggregation tier, 1 = second tier |
| dirDown | input | 1 | 0 = travelling up, 1 = travelling down |
| outValid | output | 1 | A forwarding decision is present this cycle |
| outPort | output | PORT_W | Egress port index taken from the selected hop byte |
| outDrop | output | 1 | Selected hop byte names a port at or beyond PORT_COUNT |

## Verification
On every cycle the bound checker confirms the one-cycle valid latency and the byte selection for whatever tier and direction are applied. It also checks the drop comparison against the untruncated byte, the holding of port and drop while idle, and the cleared outputs after reset. The directed scenarios give what the properties cannot. They drive known tags whose byte values sit just below, at and far above the port count. They stream a run of distinct tags with a different configuration on each cycle, and they pulse reset in the middle of a stream. The bench then compares each output with a value worked out from the requirements.

// File: rtl/srtag_pkg.sv
package srtag_pkg;

  localparam int HOP_W = 8;
  localparam int HOPS  = 4;

  typedef enum logic {
    TIER_FIRST  = 1'b0,
    TIER_SECOND = 1'b1
  } tier_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // capture a new decision
    logic clrOut;   // force outputs to zero
  } ctrl_t;

endpackage

// File: rtl/srtag_ctrl.sv
module srtag_ctrl
  import srtag_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tagValid,
  output ctrl_t ctrlStb,
  output logic  outValid
);

  always_comb begin
    ctrlStb.clrOut = rst;
    ctrlStb.loadEn = tagValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= tagValid;
  end

endmodule

// File: rtl/srtag_dp.sv
module srtag_dp
  import srtag_pkg::*;
#(
  parameter int TAG_W      = HOP_W * HOPS,
  parameter int PORT_W     = 4,
  parameter int PORT_COUNT = 12
)(
  input  logic              clk,
  input  ctrl_t             ctrlStb,
  input  logic [TAG_W-1:0]  tagWord,
  input  logic              tierSel,
  input  logic              dirDown,
  output logic [PORT_W-1:0] outPort,
  output logic              outDrop
);

  localparam int SEL_W = $clog2(HOPS);
  localparam logic [HOP_W:0] LIMIT = (HOP_W+1)'(PORT_COUNT);

  logic [HOP_W-1:0] hopLane [HOPS];
  logic [SEL_W-1:0] laneSel;
  logic [HOP_W-1:0] hopByte;
  logic             dropNext;

  // lane 0 is the most significant byte
  for (genvar g = 0; g < HOPS; g++) begin : g_lane
    assign hopLane[g] = tagWord[TAG_W-1-HOP_W*g -: HOP_W];
  end

  always_comb begin
    laneSel  = {dirDown, tierSel};
    hopByte  = hopLane[laneSel];
    dropNext = ({1'b0, hopByte} >= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (ctrlStb.clrOut) begin
      outPort <= '0;
      outDrop <= 1'b0;
    end else if (ctrlStb.loadEn) begin
      outPort <= hopByte[PORT_W-1:0];
      outDrop <= dropNext;
    end
  end

endmodule

// File: rtl/srtag_fwd.sv
module srtag_fwd
  import srtag_pkg::*;
#(
  parameter int PORT_W     = 4,
  parameter int PORT_COUNT = 12
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tagValid,
  input  logic [31:0]       tagWord,
  input  logic              tierSel,
  input  logic              dirDown,
  output logic              outValid,
  output logic [PORT_W-1:0] outPort,
  output logic              outDrop
);

  ctrl_t ctrlStb;

  srtag_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tagValid (tagValid),
    .ctrlStb  (ctrlStb),
    .outValid (outValid)
  );

  srtag_dp #(
    .TAG_W      (32),
    .PORT_W     (PORT_W),
    .PORT_COUNT (PORT_COUNT)
  ) u_dp (
    .clk     (clk),
    .ctrlStb (ctrlStb),
    .tagWord (tagWord),
    .tierSel (tierSel),
    .dirDown (dirDown),
    .outPort (outPort),
    .outDrop (outDrop)
  );

endmodule

// File: rtl/srtag_fwd_chk.sv
module srtag_fwd_chk #(
  parameter int PORT_W     = 4,
  parameter int PORT_COUNT = 12
)(
  input logic              clk,
  input logic              rst,
  input logic              tagValid,
  input logic [31:0]       tagWord,
  input logic              tierSel,
  input logic              dirDown,
  input logic              outValid,
  input logic [PORT_W-1:0] outPort,
  input logic              outDrop
);

  logic [7:0] expByte;
  logic       rstQ;

  always_comb begin
    unique case ({dirDown, tierSel})
      2'd0:    expByte = tagWord[31:24];
      2'd1:    expByte = tagWord[23:16];
      2'd2:    expByte = tagWord[15:8];
      default: expByte = tagWord[7:0];
    endcase
  end

  always_ff @(posedge clk) rstQ <= rst;

  // R4
  a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
    tagValid |=> outValid);
  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
    !tagValid |=> !outValid);

  // R1, R2, R8
  a_r1_byte_select: assert property (@(posedge clk) disable iff (rst)
    tagValid |=> outPort == $past(expByte[PORT_W-1:0]));

  // R3
  a_r3_drop_limit: assert property (@(posedge clk) disable iff (rst)
    tagValid |=> outDrop == ({1'b0, $past(expByte)} >= 9'(PORT_COUNT)));

  // R6
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !tagValid |=> $stable(outPort) && $stable(outDrop));

  // R7
  always @(posedge clk) begin
    if (rstQ) begin
      a_r7_reset_clear: assert (!outValid && outPort == '0 && !outDrop);
    end
  end

endmodule

bind srtag_fwd srtag_fwd_chk #(
  .PORT_W     (PORT_W),
  .PORT_COUNT (PORT_COUNT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tagValid (tagValid),
  .tagWord  (tagWord),
  .tierSel  (tierSel),
  .dirDown  (dirDown),
  .outValid (outValid),
  .outPort  (outPort),
  .outDrop  (outDrop)
);

// File: tb/srtag_fwd_tb.sv
module srtag_fwd_tb;

  localparam int PW = 4;
  localparam int PC = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          tagValid;
  logic [31:0]   tagWord;
  logic          tierSel;
  logic          dirDown;
  logic          outValid;
  logic [PW-1:0] outPort;
  logic          outDrop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  srtag_fwd #(.PORT_W(PW), .PORT_COUNT(PC)) u_dut (
    .clk(clk), .rst(rst), .tagValid(tagValid), .tagWord(tagWord),
    .tierSel(tierSel), .dirDown(dirDown),
    .outValid(outValid), .outPort(outPort), .outDrop(outDrop)
  );

  // byte for a tier/direction, from R1
  function automatic logic [7:0] hopOf(logic [31:0] t, logic tr, logic dn);
    case ({dn, tr})
      2'd0:    return t[31:24];
      2'd1:    return t[23:16];
      2'd2:    return t[15:8];
      default: return t[7:0];
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkResult(string req, logic [7:0] b);
    check({req, " valid"}, 32'(outValid), 32'd1);
    check({req, " port"}, 32'(outPort), 32'(b[PW-1:0]));
    check({req, " drop"}, 32'(outDrop), 32'(b >= 8'(PC)));
  endtask

  task automatic drive(logic v, logic [31:0] t, logic tr, logic dn);
    tagValid = v; tagWord = t; tierSel = tr; dirDown = dn;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; drive(1'b0, '0, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R7 reset valid", 32'(outValid), 32'd0);
    check("R7 reset port", 32'(outPort), 32'd0);
    check("R7 reset drop", 32'(outDrop), 32'd0);
    check("R4 idle valid", 32'(outValid), 32'd0);
  endtask

  // each tier/direction against one tag with distinct bytes
  task automatic testSelect();
    logic [31:0] t = 32'h0307_0A05;
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, t, i[0], i[1]);
      @(negedge clk);
      checkResult("R1 R2 select", hopOf(t, i[0], i[1]));
      drive(1'b0, t, 1'b0, 1'b0);
      @(negedge clk);
      check("R4 valid drops", 32'(outValid), 32'd0);
    end
  endtask

  // byte just below, at, and far beyond the port count
  task automatic testDrop();
    logic [7:0] vals [4] = '{8'd11, 8'd12, 8'hFF, 8'h23};
    foreach (vals[k]) begin
      drive(1'b1, {vals[k], 24'h0}, 1'b0, 1'b0);
      @(negedge clk);
      checkResult("R3 drop bound", vals[k]);
      drive(1'b0, '0, 1'b0, 1'b0);
      @(negedge clk);
    end
  endtask

  // a new tag and configuration every cycle
  task automatic testStream();
    logic [31:0] t [6] = '{32'h0102_0304, 32'h0B0C_0D0E, 32'h0900_FF01,
                           32'h2211_0A05, 32'h0000_0000, 32'hFEDC_BA98};
    drive(1'b1, t[0], 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      logic tr = k[0];
      logic dn = k[1] ^ k[2];
      drive(1'b1, t[k], tr, dn);
      @(negedge clk);
      checkResult("R5 R8 stream", hopOf(t[k], tr, dn));
    end
    drive(1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1);
    @(negedge clk);
    check("R4 end of stream", 32'(outValid), 32'd0);
  endtask

  // idle cycles with changing tag and config must not move outputs
  task automatic testHold();
    logic [31:0] t = 32'h0600_0000;
    drive(1'b1, t, 1'b0, 1'b0);
    @(negedge clk);
    checkResult("R6 load", 8'h06);
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 32'hFFFF_FFFF ^ 32'(k), k[0], 1'b1);
      @(negedge clk);
      check("R6 hold port", 32'(outPort), 32'd6);
      check("R6 hold drop", 32'(outDrop), 32'd0);
      check("R6 idle valid", 32'(outValid), 32'd0);
    end
  endtask

  // reset alongside a valid tag wins
  task automatic testResetPriority();
    drive(1'b1, 32'h0000_00FF, 1'b1, 1'b1);
    @(negedge clk);
    checkResult("R7 pre", 8'hFF);
    rst = 1'b1;
    drive(1'b1, 32'h0000_00FF, 1'b1, 1'b1);
    @(negedge clk);
    check("R7 priority valid", 32'(outValid), 32'd0);
    check("R7 priority port", 32'(outPort), 32'd0);
    check("R7 priority drop", 32'(outDrop), 32'd0);
    rst = 1'b0;
    drive(1'b1, 32'h0000_0900, 1'b0, 1'b1);
    @(negedge clk);
    checkResult("R7 resume", 8'h09);
    drive(1'b0, '0, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, '0, 1'b0, 1'b0);
    testReset();
    testSelect();
    testDrop();
    testStream();
    testHold();
    testResetPriority();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule